// File: doc/BRIEF.md
# Status Register Write-Protection Controller

This block holds the status byte of a serial memory device and rules on every write that the command decoder asks for. Decoded one-cycle strobes arrive from the serial front end: arm write-enable, disarm write-enable, write status, set flag, clear flag and array write. The block judges each write against three things: the write-enable latch, a protect-enable bit together with an active-low write-protect pin, and a protected address range chosen by two lock bits. For each write strobe it answers with a grant or a deny pulse. The status byte is always available for reads.

The write-enable latch is a two-state machine. `WEL_CLEAR` goes to `WEL_ARMED` on an arm strobe that comes without a disarm strobe. `WEL_ARMED` goes back to `WEL_CLEAR` on a disarm strobe or on any write it granted. The bits that would be nonvolatile in a real part are plain flops here, loaded with their defaults at reset.

Top module: `sr_protect_ctrl`

## Requirements
- R1: `cmd_wren` arms the write-enable latch and `cmd_wrdi` disarms it. The latch reads as status bit 1 from the cycle after the strobe. When both strobes come in the same cycle, disarm wins.
- R2: While the latch reads 0, every status write and every array write is denied, whatever the pin, the protect-enable bit or the address.
- R3: While the latch reads 1 and either the protect-enable bit is 0 or `wp_n` is 1, a status write is granted. The write loads protect-enable (bit 7), watchdog select (bits 5:4) and lock (bits 3:2) from the same positions of `sr_wdata`. Status bit 6 always reads 0.
- R4: While `wp_n` is 0 and the protect-enable bit is 1, every status write is denied and bits 7 and 5:2 stay as they were. Unprotected array addresses are still granted while the latch reads 1.
- R5: The lock field selects the protected range of the 12-bit address space:
  - 00: nothing is protected.
  - 01: 0xC00 to 0xFFF is protected.
  - 10: 0x800 to 0xFFF is protected.
  - 11: every address is protected.
- R6: An array write to a protected address is always denied, even with the latch set and the pin high.
- R7: After reset the status byte reads 0x30. That is protect-enable 0, watchdog select 11 (disabled), lock 00, latch 0 and flag 0.
- R8: `cmd_sflag` sets the flag (status bit 0) and `cmd_rflag` clears it. When both come in the same cycle, clear wins.
- R9: A granted write clears the latch. A denied write leaves the latch unchanged.
- R10: Each status-write or array-write strobe produces exactly one pulse, on its grant or on its deny output, in the next cycle. No pulse appears in a cycle that follows no such strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wren | input | 1 | Arm write-enable latch strobe |
| cmd_wrdi | input | 1 | Disarm write-enable latch strobe |
| cmd_wrsr | input | 1 | Status write strobe |
| cmd_sflag | input | 1 | Set flag strobe |
| cmd_rflag | input | 1 | Clear flag strobe |
| cmd_arr_wr | input | 1 | Array write request strobe |
| wp_n | input | 1 | Write-protect pin, active low |
| arr_addr | input | 12 | Target address of the array write |
| sr_wdata | input | 8 | Data for a status write |
| status_q | output | 8 | Status byte for reads |
| sr_grant | output | 1 | Status write granted (one-cycle pulse) |
| sr_deny | output | 1 | Status write denied (one-cycle pulse) |
| arr_grant | output | 1 | Array write granted (one-cycle pulse) |
| arr_deny | output | 1 | Array write denied (one-cycle pulse) |

## Verification
Every result is due one clock after its strobe: the grant or deny pulse, the updated status byte, and the latch and flag bits. The bench therefore drives each strobe for one cycle from a falling edge and samples all outputs on the next falling edge, after exactly one rising edge. A sweep covers every lock code, protect-enable value, pin level and latch state against addresses on both sides of each range boundary. The expected status byte and verdicts come from a bench model written from the requirements. Directed steps then cover simultaneous strobes, latch retention after a deny, and quiet outputs in the cycle after a pulse.

// File: rtl/sr_protect_pkg.sv
package sr_protect_pkg;
    typedef enum logic [0:0] {
        WEL_CLEAR = 1'b0,
        WEL_ARMED = 1'b1
    } wel_state_e;

    localparam int SR_W      = 8;
    localparam int BIT_PEN   = 7;
    localparam int BIT_WD_HI = 5;
    localparam int BIT_WD_LO = 4;
    localparam int BIT_LK_HI = 3;
    localparam int BIT_LK_LO = 2;
    localparam int BIT_WEL   = 1;
    localparam int BIT_FLAG  = 0;
endpackage

// File: rtl/sr_range_dec.sv
module sr_range_dec #(
    parameter int ADDR_W = 12
) (
    input  logic [1:0]        lock,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    // lock selects the top quarter, the top half or the whole space
    always_comb begin
        unique case (lock)
            2'b00: hit = 1'b0;
            2'b01: hit = (addr[ADDR_W-1:ADDR_W-2] == 2'b11);
            2'b10: hit = addr[ADDR_W-1];
            2'b11: hit = 1'b1;
            default: hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/sr_store.sv
module sr_store #(
    parameter logic [1:0] WD_RESET   = 2'b11,
    parameter logic [1:0] LOCK_RESET = 2'b00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_pen,
    input  logic [1:0] wr_wd,
    input  logic [1:0] wr_lock,
    input  logic       sflag,
    input  logic       rflag,
    output logic       pen,
    output logic [1:0] wd,
    output logic [1:0] lock,
    output logic       flag
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pen  <= 1'b0;
            wd   <= WD_RESET;
            lock <= LOCK_RESET;
        end else if (wr_en) begin
            pen  <= wr_pen;
            wd   <= wr_wd;
            lock <= wr_lock;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     flag <= 1'b0;
        else if (rflag) flag <= 1'b0;
        else if (sflag) flag <= 1'b1;
    end
endmodule

// File: rtl/sr_grant_fsm.sv
module sr_grant_fsm
    import sr_protect_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_we,
    input  logic clr_we,
    input  logic sr_req,
    input  logic arr_req,
    input  logic pen,
    input  logic wp_n,
    input  logic prot_hit,
    output logic wel,
    output logic sr_ok,
    output logic sr_grant,
    output logic sr_deny,
    output logic arr_grant,
    output logic arr_deny
);
    wel_state_e state, state_n;
    logic       arr_ok;
    logic       sr_open;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= WEL_CLEAR;
        else        state <= state_n;
    end

    // verdicts and next state
    always_comb begin
        sr_open = !pen || wp_n;
        sr_ok   = sr_req  && (state == WEL_ARMED) && sr_open;
        arr_ok  = arr_req && (state == WEL_ARMED) && !prot_hit;
        state_n = state;
        unique case (state)
            WEL_CLEAR: if (set_we && !clr_we) state_n = WEL_ARMED;
            WEL_ARMED: if (clr_we || sr_ok || arr_ok) state_n = WEL_CLEAR;
            default:   state_n = WEL_CLEAR;
        endcase
    end

    // registered grant and deny pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_grant  <= 1'b0;
            sr_deny   <= 1'b0;
            arr_grant <= 1'b0;
            arr_deny  <= 1'b0;
        end else begin
            sr_grant  <= sr_ok;
            sr_deny   <= sr_req && !sr_ok;
            arr_grant <= arr_ok;
            arr_deny  <= arr_req && !arr_ok;
        end
    end

    assign wel = (state == WEL_ARMED);
endmodule

// File: rtl/sr_protect_ctrl.sv
module sr_protect_ctrl
    import sr_protect_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_wrsr,
    input  logic              cmd_sflag,
    input  logic              cmd_rflag,
    input  logic              cmd_arr_wr,
    input  logic              wp_n,
    input  logic [ADDR_W-1:0] arr_addr,
    input  logic [SR_W-1:0]   sr_wdata,
    output logic [SR_W-1:0]   status_q,
    output logic              sr_grant,
    output logic              sr_deny,
    output logic              arr_grant,
    output logic              arr_deny
);
    logic       pen, flag, wel, hit, sr_ok;
    logic [1:0] wd, lock;
    logic       unused_wdata;

    assign unused_wdata = ^{sr_wdata[6], sr_wdata[BIT_WEL], sr_wdata[BIT_FLAG]};

    sr_range_dec #(.ADDR_W(ADDR_W)) u_range (
        .lock (lock),
        .addr (arr_addr),
        .hit  (hit)
    );

    sr_grant_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_we    (cmd_wren),
        .clr_we    (cmd_wrdi),
        .sr_req    (cmd_wrsr),
        .arr_req   (cmd_arr_wr),
        .pen       (pen),
        .wp_n      (wp_n),
        .prot_hit  (hit),
        .wel       (wel),
        .sr_ok     (sr_ok),
        .sr_grant  (sr_grant),
        .sr_deny   (sr_deny),
        .arr_grant (arr_grant),
        .arr_deny  (arr_deny)
    );

    sr_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sr_ok),
        .wr_pen  (sr_wdata[BIT_PEN]),
        .wr_wd   (sr_wdata[BIT_WD_HI:BIT_WD_LO]),
        .wr_lock (sr_wdata[BIT_LK_HI:BIT_LK_LO]),
        .sflag   (cmd_sflag),
        .rflag   (cmd_rflag),
        .pen     (pen),
        .wd      (wd),
        .lock    (lock),
        .flag    (flag)
    );

    assign status_q = {pen, 1'b0, wd, lock, wel, flag};
endmodule

// File: rtl/sr_protect_chk.sv
module sr_protect_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_wrsr,
    input logic       cmd_arr_wr,
    input logic       cmd_sflag,
    input logic       cmd_rflag,
    input logic       wp_n,
    input logic [7:0] status_q,
    input logic       sr_grant,
    input logic       sr_deny,
    input logic       arr_grant,
    input logic       arr_deny
);
    p_unarmed_sr_deny_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wrsr && !status_q[1] |=> sr_deny && !sr_grant);

    p_unarmed_arr_deny_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_arr_wr && !status_q[1] |=> arr_deny && !arr_grant);

    p_rom_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wrsr && !wp_n && status_q[7] |=> sr_deny && $stable(status_q[7:2]));

    p_full_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_arr_wr && (status_q[3:2] == 2'b11) |=> arr_deny);

    p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_sflag && !cmd_rflag |=> status_q[0]);

    p_flag_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rflag |=> !status_q[0]);

    p_wel_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sr_grant || arr_grant |-> !status_q[1]);

    p_one_verdict_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(sr_grant && sr_deny) && !(arr_grant && arr_deny));

    p_sr_pulse_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wrsr |=> !sr_grant && !sr_deny);

    p_arr_pulse_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_arr_wr |=> !arr_grant && !arr_deny);

    p_bit6_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !status_q[6]);
endmodule

bind sr_protect_ctrl sr_protect_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wrsr   (cmd_wrsr),
    .cmd_arr_wr (cmd_arr_wr),
    .cmd_sflag  (cmd_sflag),
    .cmd_rflag  (cmd_rflag),
    .wp_n       (wp_n),
    .status_q   (status_q),
    .sr_grant   (sr_grant),
    .sr_deny    (sr_deny),
    .arr_grant  (arr_grant),
    .arr_deny   (arr_deny)
);

// File: tb/sr_protect_ctrl_tb.sv
`timescale 1ns/1ps
module sr_protect_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_sflag = 0, cmd_rflag = 0, cmd_arr_wr = 0;
    logic wp_n = 1'b1;
    logic [11:0] arr_addr = '0;
    logic [7:0]  sr_wdata = '0;
    logic [7:0]  status_q;
    logic sr_grant, sr_deny, arr_grant, arr_deny;

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic m_pen, m_wel, m_flag;
    logic [1:0] m_wd, m_lock;

    always #2 clk = ~clk;

    sr_protect_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
        .cmd_wrsr(cmd_wrsr), .cmd_sflag(cmd_sflag), .cmd_rflag(cmd_rflag),
        .cmd_arr_wr(cmd_arr_wr), .wp_n(wp_n), .arr_addr(arr_addr),
        .sr_wdata(sr_wdata), .status_q(status_q), .sr_grant(sr_grant),
        .sr_deny(sr_deny), .arr_grant(arr_grant), .arr_deny(arr_deny)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic prot(input logic [1:0] lk, input logic [11:0] a);
        case (lk)
            2'd0: prot = 1'b0;
            2'd1: prot = (a >= 12'hC00);
            2'd2: prot = (a >= 12'h800);
            default: prot = 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] m_status();
        m_status = {m_pen, 1'b0, m_wd, m_lock, m_wel, m_flag};
    endfunction

    // cmd bit order: {arr, wrsr, rflag, sflag, wrdi, wren}
    task automatic issue(input logic [5:0] cmd, input logic [7:0] d, input logic [11:0] a, input string req);
        logic g_sr, g_arr;
        @(negedge clk);
        {cmd_arr_wr, cmd_wrsr, cmd_rflag, cmd_sflag, cmd_wrdi, cmd_wren} = cmd;
        sr_wdata = d;
        arr_addr = a;
        g_sr  = cmd[4] && m_wel && (!m_pen || wp_n);
        g_arr = cmd[5] && m_wel && !prot(m_lock, a);
        if (g_sr) begin
            m_pen = d[7]; m_wd = d[5:4]; m_lock = d[3:2];
        end
        if (cmd[3])      m_flag = 1'b0;
        else if (cmd[2]) m_flag = 1'b1;
        if (g_sr || g_arr) m_wel = 1'b0;
        else if (cmd[1])   m_wel = 1'b0;
        else if (cmd[0])   m_wel = 1'b1;
        @(negedge clk);
        {cmd_arr_wr, cmd_wrsr, cmd_rflag, cmd_sflag, cmd_wrdi, cmd_wren} = '0;
        chk({req, " status byte"}, status_q, m_status());
        chk({req, " sr verdict"}, {sr_grant, sr_deny}, {g_sr, cmd[4] && !g_sr});
        chk({req, " arr verdict"}, {arr_grant, arr_deny}, {g_arr, cmd[5] && !g_arr});
    endtask

    initial begin
        m_pen = 0; m_wel = 0; m_flag = 0; m_wd = 2'b11; m_lock = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 reset byte", status_q, 8'h30);
        chk("R10 idle", {sr_grant, sr_deny, arr_grant, arr_deny}, 4'h0);

        // R1: arm, disarm, both at once
        issue(6'b000001, 8'h00, 12'h000, "R1 arm");
        issue(6'b000010, 8'h00, 12'h000, "R1 disarm");
        issue(6'b000001, 8'h00, 12'h000, "R1 rearm");
        issue(6'b000011, 8'h00, 12'h000, "R1 both");
        chk("R1 disarm wins", status_q[1], 1'b0);

        // R8: flag
        issue(6'b000100, 8'h00, 12'h000, "R8 set");
        chk("R8 flag set", status_q[0], 1'b1);
        issue(6'b001100, 8'h00, 12'h000, "R8 both");
        chk("R8 clear wins", status_q[0], 1'b0);

        // main sweep
        for (int lk = 0; lk < 4; lk++) begin
            for (int pe = 0; pe < 2; pe++) begin
                for (int wp = 0; wp < 2; wp++) begin
                    for (int we = 0; we < 2; we++) begin
                        for (int ai = 0; ai < 8; ai++) begin
                            logic [11:0] a;
                            logic [7:0]  d;
                            a = 12'(ai / 2) * 12'h400 + ((ai % 2 == 1) ? 12'h3FF : 12'h000);
                            d = {pe[0], 1'b0, 2'(lk + pe), lk[1:0], 2'b00};
                            wp_n = 1'b1;
                            issue(6'b000001, 8'h00, 12'h000, "R1 arm");
                            issue(6'b010000, d, 12'h000, "R3 program");
                            wp_n = wp[0];
                            if (we != 0) issue(6'b000001, 8'h00, 12'h000, "R1 arm");
                            issue(6'b100000, 8'h00, a, "R5 R6 R2 array");
                            if (we != 0) issue(6'b000001, 8'h00, 12'h000, "R9 arm");
                            issue(6'b010000, 8'hFF ^ d, 12'h000, "R4 R3 R2 status");
                        end
                    end
                end
            end
        end

        // R9: denied write keeps latch set
        wp_n = 1'b1;
        issue(6'b000001, 8'h00, 12'h000, "R9 arm");
        issue(6'b010000, 8'h0C, 12'h000, "R9 lock all");
        issue(6'b000001, 8'h00, 12'h000, "R9 arm");
        issue(6'b100000, 8'h00, 12'h123, "R9 denied");
        chk("R9 latch kept", status_q[1], 1'b1);
        @(negedge clk);
        chk("R10 quiet after pulse", {sr_grant, sr_deny, arr_grant, arr_deny}, 4'h0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule